// File: doc/BRIEF.md
# Maskable Interrupt Request Unit

This unit gathers six interrupt sources (two external inputs, overflows from three timers, and one serial-port event) and hands one pending request with a source index to a CPU sequencer. Each source has its own enable bit, and a global enable bit gates all of them. Flag updates and request polling follow a machine cycle of six states, each split into two phases. The unit counts this cycle itself and reports the current state and phase to the sequencer.

The flags for timers 0 and 1 are set late in the machine cycle. The poll in that cycle has already sampled the flags, so these requests become visible one cycle later. The timer-2 flags are set early and are seen by the poll of the same cycle. The timer-2 request is the OR of an overflow flag and an external-event flag. Hardware never clears either of them, and the serial flag is also left to software. When the sequencer acknowledges a request, the unit clears the timer-0 and timer-1 flags and the flags of edge-mode external inputs. Software can clear any flag at any time.

Top module: `irq_request_unit`

## Requirements
- R1: After reset the unit reports state 1, phase index 0. The phase index steps 0,1 on each clock. The state advances when the phase wraps, and the cycle wraps to state 1 after state 6, phase index 1, giving 12 clocks per machine cycle.
- R2: The enable register is written through `en_we`/`en_wdata` and read on `en_rdata`. The bit layout is: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2, bit 7 global. After reset the register is 0.
- R3: Bit 6 of the enable register ignores writes and always reads 0.
- R4: While bit 7 is 0, `irq_valid` does not rise, even when flags of enabled sources are set.
- R5: A source whose enable bit is 0 is not presented, and the next enabled pending source in priority order is presented instead.
- R6: A timer-0 or timer-1 overflow pulse that arrives no later than the clock at state 5, phase index 1 sets its flag at that clock's edge. The request appears after the poll edge of the following machine cycle.
- R7: A timer-2 overflow pulse that arrives no later than the clock at state 2, phase index 1 sets its flag at that edge. The request appears after the poll edge (state 5, phase index 1) of the same machine cycle.
- R8: The timer-2 request (`irq_src` 5) is the OR of the overflow flag (`irq_flags` bit 5) and the external-event flag (`irq_flags` bit 6). The external-event flag is set on the same edge as the overflow flag.
- R9: An acknowledge of source 4 or 5 clears no flag. The request is presented again at the next poll until software clears the flag.
- R10: An acknowledge while `irq_valid` is 1 drops `irq_valid` on the next edge. It clears flag 1 or 3 for sources 1 or 3, and flag 0 or 2 for sources 0 or 2 only when that input is in edge mode.
- R11: When several sources are live, the lowest index wins, in the order external 0 (0), timer 0 (1), external 1 (2), timer 1 (3), serial (4), timer 2 (5).
- R12: External inputs are sampled at the edge of state 5, phase index 1. In edge mode (`ext_edge` bit 1), flag 0 or 2 is set when a sample is 1 and the previous sample was 0. In level mode, the flag equals the latest sample and ignores clears.
- R13: A `sw_clr` bit clears the matching `irq_flags` bit on the next edge. A set on the same edge takes precedence over the clear.
- R14: `irq_valid` and `irq_src` change only at the poll edge (state 5, phase index 1). The one exception is the drop caused by an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one machine cycle is 12 clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register contents |
| ext_pin | input | 2 | External request inputs, active high, synchronous to clk |
| ext_edge | input | 2 | Per external input: 1 edge mode, 0 level mode |
| tmr_ovf | input | 3 | One-clock overflow pulses of timers 0, 1, 2 |
| t2_ext_evt | input | 1 | One-clock timer-2 external event pulse |
| ser_evt | input | 1 | One-clock serial transfer-done pulse |
| sw_clr | input | 7 | Per-flag software clear, bit order as `irq_flags` |
| ack | input | 1 | Sequencer acknowledge of the presented request |
| irq_valid | output | 1 | A request is pending |
| irq_src | output | 3 | Index of the presented source |
| irq_flags | output | 7 | Flags: 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial, 5 tmr2 overflow, 6 tmr2 event |
| mc_state | output | 3 | Current machine-cycle state, 1 to 6 |
| mc_phase | output | 1 | Current phase index, 0 or 1 |

## Verification
The bench uses the default 6-state, 2-phase cycle with flags set at states 5 and 2 and polling at state 5. The gap between timer-0/1 and timer-2 polling is therefore exactly one 12-clock cycle, and the directed tests can place pulses on either side of each strobe. With a cycle this short, a few thousand random clocks cover every source. They also cover acknowledges that land on poll edges and clears that coincide with sets, all compared each cycle against a bench model.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  localparam int unsigned NUM_SRC  = 6;
  localparam int unsigned NUM_FLAG = 7;
  localparam int unsigned F_EX0  = 0;
  localparam int unsigned F_TF0  = 1;
  localparam int unsigned F_EX1  = 2;
  localparam int unsigned F_TF1  = 3;
  localparam int unsigned F_SER  = 4;
  localparam int unsigned F_TF2  = 5;
  localparam int unsigned F_EXF2 = 6;
  localparam int unsigned EN_UNUSED = 6;
  localparam int unsigned EN_GLOBAL = 7;
  typedef logic [2:0] src_idx_t;
endpackage

// File: rtl/irq_mc_timer.sv
module irq_mc_timer #(
  parameter int unsigned STATES     = 6,
  parameter int unsigned PHASES     = 2,
  parameter int unsigned T01_STATE  = 5,
  parameter int unsigned T2_STATE   = 2,
  parameter int unsigned POLL_STATE = 5,
  parameter int unsigned STB_PHASE  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [$clog2(STATES+1)-1:0]  state_no,
  output logic [$clog2(PHASES)-1:0]    phase_no,
  output logic                         stb_t01,
  output logic                         stb_t2,
  output logic                         stb_poll
);
  localparam int unsigned SW = $clog2(STATES+1);
  localparam int unsigned PW = $clog2(PHASES);
  localparam logic [SW-1:0] ST_LAST = SW'(STATES-1);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASES-1);
  localparam logic [PW-1:0] PH_STB  = PW'(STB_PHASE-1);

  logic [SW-1:0] st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    if (ph_q == PH_LAST) begin
      ph_d = '0;
      st_d = (st_q == ST_LAST) ? '0 : st_q + SW'(1);
    end else begin
      ph_d = ph_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign state_no = st_q + SW'(1);
  assign phase_no = ph_q;
  assign stb_t01  = (st_q == SW'(T01_STATE-1))  && (ph_q == PH_STB);
  assign stb_t2   = (st_q == SW'(T2_STATE-1))   && (ph_q == PH_STB);
  assign stb_poll = (st_q == SW'(POLL_STATE-1)) && (ph_q == PH_STB);

  // R1: state index stays inside the cycle
  a_r1_state_range: assert property (@(posedge clk) disable iff (!rst_n)
    st_q <= ST_LAST);
  // R1: state only moves when the phase wraps
  a_r1_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_LAST) |=> $stable(st_q));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_req_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb_t01,
  input  logic                stb_t2,
  input  logic                stb_poll,
  input  logic [1:0]          ext_pin,
  input  logic [1:0]          ext_edge,
  input  logic [2:0]          tmr_ovf,
  input  logic                t2_evt,
  input  logic                ser_evt,
  input  logic [NUM_FLAG-1:0] sw_clr,
  input  logic [NUM_FLAG-1:0] ack_clr,
  output logic [NUM_FLAG-1:0] flags,
  output logic [NUM_SRC-1:0]  src_req
);
  localparam int unsigned NPEND = 4;

  logic [NPEND-1:0]    ev, stb, pend_q, pend_d;
  logic [NUM_FLAG-1:0] flag_q, flag_d, set, clr;
  logic [1:0]          prev_q, prev_d;

  function automatic int unsigned pend_flag(input int unsigned i);
    case (i)
      0:       return F_TF0;
      1:       return F_TF1;
      2:       return F_TF2;
      default: return F_EXF2;
    endcase
  endfunction

  assign ev  = {t2_evt, tmr_ovf};
  assign stb = {stb_t2, stb_t2, stb_t01, stb_t01};
  assign clr = sw_clr | ack_clr;

  always_comb begin
    pend_d = pend_q;
    set    = '0;
    for (int unsigned i = 0; i < NPEND; i++) begin
      if (stb[i]) begin
        set[pend_flag(i)] = pend_q[i] | ev[i];
        pend_d[i]         = 1'b0;
      end else begin
        pend_d[i] = pend_q[i] | ev[i];
      end
    end
    set[F_SER] = ser_evt;
    set[F_EX0] = stb_poll & ext_pin[0] & ~prev_q[0];
    set[F_EX1] = stb_poll & ext_pin[1] & ~prev_q[1];
    flag_d = set | (flag_q & ~clr);
    if (!ext_edge[0]) flag_d[F_EX0] = stb_poll ? ext_pin[0] : flag_q[F_EX0];
    if (!ext_edge[1]) flag_d[F_EX1] = stb_poll ? ext_pin[1] : flag_q[F_EX1];
    prev_d = stb_poll ? ext_pin : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      flag_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      flag_q <= flag_d;
      prev_q <= prev_d;
    end
  end

  assign flags   = flag_q;
  assign src_req = {flag_q[F_TF2] | flag_q[F_EXF2], flag_q[F_SER:F_EX0]};

  // R6: timer-0 flag only rises at its late-cycle strobe
  a_r6_tf0_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[F_TF0]) |-> $past(stb_t01));
  // R7: timer-2 overflow flag only rises at its early-cycle strobe
  a_r7_tf2_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[F_TF2]) |-> $past(stb_t2));
  // R9: hardware never drops the timer-2 overflow flag
  a_r9_tf2_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[F_TF2] && !sw_clr[F_TF2]) |=> flag_q[F_TF2]);
  // R9: hardware never drops the serial flag
  a_r9_ser_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[F_SER] && !sw_clr[F_SER]) |=> flag_q[F_SER]);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_req_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output src_idx_t           idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = src_idx_t'(i);
      end
    end
  end

  // R11: the chosen source is live and no lower index is live
  always_comb begin
    if (any) begin
      a_r11_winner_live: assert (req[idx]);
      for (int i = 0; i < NUM_SRC; i++) begin
        if (i < int'(idx)) a_r11_no_lower: assert (!req[i]);
      end
    end
  end
endmodule

// File: rtl/irq_request_unit.sv
module irq_request_unit
  import irq_req_pkg::*;
#(
  parameter int unsigned STATES     = 6,
  parameter int unsigned PHASES     = 2,
  parameter int unsigned T01_STATE  = 5,
  parameter int unsigned T2_STATE   = 2,
  parameter int unsigned POLL_STATE = 5,
  parameter int unsigned STB_PHASE  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_we,
  input  logic [7:0]                  en_wdata,
  output logic [7:0]                  en_rdata,
  input  logic [1:0]                  ext_pin,
  input  logic [1:0]                  ext_edge,
  input  logic [2:0]                  tmr_ovf,
  input  logic                        t2_ext_evt,
  input  logic                        ser_evt,
  input  logic [NUM_FLAG-1:0]         sw_clr,
  input  logic                        ack,
  output logic                        irq_valid,
  output logic [2:0]                  irq_src,
  output logic [NUM_FLAG-1:0]         irq_flags,
  output logic [$clog2(STATES+1)-1:0] mc_state,
  output logic [$clog2(PHASES)-1:0]   mc_phase
);
  localparam logic [7:0] EN_WMASK = ~(8'd1 << EN_UNUSED);

  logic                stb_t01, stb_t2, stb_poll;
  logic [7:0]          en_q, en_d;
  logic [NUM_FLAG-1:0] ack_clr;
  logic [NUM_SRC-1:0]  src_req, src_live;
  logic                pick_any, ack_hit;
  src_idx_t            pick_idx;
  logic                valid_q, valid_d;
  src_idx_t            src_q, src_d;

  irq_mc_timer #(
    .STATES(STATES), .PHASES(PHASES), .T01_STATE(T01_STATE),
    .T2_STATE(T2_STATE), .POLL_STATE(POLL_STATE), .STB_PHASE(STB_PHASE)
  ) i_cycle (
    .clk(clk), .rst_n(rst_n), .state_no(mc_state), .phase_no(mc_phase),
    .stb_t01(stb_t01), .stb_t2(stb_t2), .stb_poll(stb_poll)
  );

  irq_flag_bank i_flags (
    .clk(clk), .rst_n(rst_n), .stb_t01(stb_t01), .stb_t2(stb_t2),
    .stb_poll(stb_poll), .ext_pin(ext_pin), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .t2_evt(t2_ext_evt), .ser_evt(ser_evt),
    .sw_clr(sw_clr), .ack_clr(ack_clr), .flags(irq_flags), .src_req(src_req)
  );

  assign src_live = src_req & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[EN_GLOBAL]}};

  irq_pick i_pick (.req(src_live), .any(pick_any), .idx(pick_idx));

  always_comb begin
    ack_hit = ack & valid_q;
    ack_clr = '0;
    if (ack_hit) begin
      case (src_q)
        3'd0:    ack_clr[F_EX0] = ext_edge[0];
        3'd1:    ack_clr[F_TF0] = 1'b1;
        3'd2:    ack_clr[F_EX1] = ext_edge[1];
        3'd3:    ack_clr[F_TF1] = 1'b1;
        default: ack_clr = '0;
      endcase
    end
  end

  always_comb begin
    valid_d = valid_q;
    src_d   = src_q;
    if (ack_hit) begin
      valid_d = 1'b0;
    end else if (stb_poll) begin
      valid_d = pick_any;
      src_d   = pick_idx;
    end
    en_d = en_we ? (en_wdata & EN_WMASK) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      en_q    <= '0;
    end else begin
      valid_q <= valid_d;
      src_q   <= src_d;
      en_q    <= en_d;
    end
  end

  assign irq_valid = valid_q;
  assign irq_src   = src_q;
  assign en_rdata  = en_q;

  // R3: unimplemented enable bit never holds a 1
  a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    en_rdata[EN_UNUSED] == 1'b0);
  // R4: a request only rises when the global enable was set
  a_r4_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(en_q[EN_GLOBAL]));
  // R10: an accepted acknowledge drops the request
  a_r10_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid) |=> !irq_valid);
  // R14: request output holds between poll edges
  a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_poll && !ack) |=> ($stable(irq_valid) && $stable(irq_src)));
endmodule

// File: tb/test_irq_request_unit.sv
module test_irq_request_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       en_we = 0;
  logic [7:0] en_wdata = 0;
  logic [1:0] ext_pin = 0, ext_edge = 0;
  logic [2:0] tmr_ovf = 0;
  logic       t2_ext_evt = 0, ser_evt = 0, ack = 0;
  logic [6:0] sw_clr = 0;
  logic [7:0] en_rdata;
  logic       irq_valid;
  logic [2:0] irq_src;
  logic [6:0] irq_flags;
  logic [2:0] mc_state;
  logic [0:0] mc_phase;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  irq_request_unit i_irq_request_unit (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .en_rdata(en_rdata), .ext_pin(ext_pin), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .t2_ext_evt(t2_ext_evt), .ser_evt(ser_evt),
    .sw_clr(sw_clr), .ack(ack), .irq_valid(irq_valid), .irq_src(irq_src),
    .irq_flags(irq_flags), .mc_state(mc_state), .mc_phase(mc_phase)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] pick(input logic [5:0] r);
    logic [2:0] p = 3'd0;
    for (int i = 5; i >= 0; i--) if (r[i]) p = 3'(i);
    return p;
  endfunction

  // Reference model built from the requirements
  int         m_cnt = 0;
  logic [3:0] m_pend = 0;
  logic [6:0] m_fl = 0;
  logic [1:0] m_prev = 0;
  logic [7:0] m_en = 0;
  logic       m_val = 0;
  logic [2:0] m_src = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0; m_fl = 0; m_prev = 0; m_en = 0; m_val = 0; m_src = 0;
    end else begin
      logic s01, s2, ackv;
      logic [6:0] clr, set, nf;
      logic [5:0] req;
      logic [3:0] np;
      s01 = (m_cnt == 9);
      s2  = (m_cnt == 3);
      ackv = ack && m_val;
      clr = sw_clr;
      if (ackv) begin
        case (m_src)
          3'd0: clr[0] = clr[0] | ext_edge[0];
          3'd1: clr[1] = 1'b1;
          3'd2: clr[2] = clr[2] | ext_edge[1];
          3'd3: clr[3] = 1'b1;
          default: ;
        endcase
      end
      set = 0;
      if (s01) begin
        set[1] = m_pend[0] | tmr_ovf[0];
        set[3] = m_pend[1] | tmr_ovf[1];
        np[1:0] = 2'b00;
      end else np[1:0] = m_pend[1:0] | tmr_ovf[1:0];
      if (s2) begin
        set[5] = m_pend[2] | tmr_ovf[2];
        set[6] = m_pend[3] | t2_ext_evt;
        np[3:2] = 2'b00;
      end else np[3:2] = m_pend[3:2] | {t2_ext_evt, tmr_ovf[2]};
      set[4] = ser_evt;
      set[0] = s01 & ext_pin[0] & ~m_prev[0];
      set[2] = s01 & ext_pin[1] & ~m_prev[1];
      nf = set | (m_fl & ~clr);
      if (!ext_edge[0]) nf[0] = s01 ? ext_pin[0] : m_fl[0];
      if (!ext_edge[1]) nf[2] = s01 ? ext_pin[1] : m_fl[2];
      req = {m_fl[5] | m_fl[6], m_fl[4:0]} & m_en[5:0] & {6{m_en[7]}};
      if (ackv) m_val = 0;
      else if (s01) begin m_val = |req; m_src = pick(req); end
      if (s01) m_prev = ext_pin;
      if (en_we) m_en = en_wdata & 8'hBF;
      m_fl = nf;
      m_pend = np;
      m_cnt = (m_cnt == 11) ? 0 : m_cnt + 1;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 state", int'(mc_state), m_cnt / 2 + 1);
      check("R1 phase", int'(mc_phase), m_cnt % 2);
      check("R2 enable readback", int'(en_rdata), int'(m_en));
      check("R13 flags", int'(irq_flags), int'(m_fl));
      check("R14 valid", int'(irq_valid), int'(m_val));
      check("R11 source", int'(irq_src), int'(m_src));
    end
  end

  task automatic pulse_end;
    @(negedge clk);
    tmr_ovf = 0; t2_ext_evt = 0; ser_evt = 0; sw_clr = 0; ack = 0; en_we = 0;
  endtask

  task automatic go_to(input int c);
    @(negedge clk);
    while (m_cnt != c) @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_we = 1; en_wdata = v;
    pulse_end();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset state", int'(mc_state), 1);
    check("R1 reset phase", int'(mc_phase), 0);
    check("R2 reset enable", int'(en_rdata), 0);
    check("R14 reset valid", int'(irq_valid), 0);

    // R3: bit 6 not writable
    wr_en(8'hFF);
    check("R3 unused bit reads 0", int'(en_rdata), 8'hBF);
    wr_en(8'h00);

    // R6: timer 0 polled one cycle late
    ext_edge = 2'b11;
    wr_en(8'h82);
    go_to(2); tmr_ovf[0] = 1; pulse_end();
    go_to(10);
    check("R6 t0 not in same cycle", int'(irq_valid), 0);
    check("R6 t0 flag set", int'(irq_flags[1]), 1);
    go_to(10);
    check("R6 t0 next cycle valid", int'(irq_valid), 1);
    check("R6 t0 source", int'(irq_src), 1);
    ack = 1; pulse_end();
    check("R10 ack drops valid", int'(irq_valid), 0);
    check("R10 ack clears t0 flag", int'(irq_flags[1]), 0);

    // R7: timer 2 polled in same cycle
    wr_en(8'hA0);
    go_to(1); tmr_ovf[2] = 1; pulse_end();
    go_to(10);
    check("R7 t2 same cycle valid", int'(irq_valid), 1);
    check("R7 t2 source", int'(irq_src), 5);
    ack = 1; pulse_end();
    check("R10 t2 ack drops valid", int'(irq_valid), 0);
    go_to(10);
    check("R9 t2 flag kept", int'(irq_flags[5]), 1);
    check("R9 t2 presented again", int'(irq_valid), 1);
    sw_clr[5] = 1; pulse_end();
    go_to(10);
    check("R13 sw clear flag", int'(irq_flags[5]), 0);
    check("R13 sw clear request", int'(irq_valid), 0);

    // R8: external event flag alone raises timer-2 request
    go_to(0); t2_ext_evt = 1; pulse_end();
    go_to(10);
    check("R8 event flag", int'(irq_flags[6]), 1);
    check("R8 event request", int'(irq_valid), 1);
    check("R8 event source", int'(irq_src), 5);
    sw_clr[6] = 1; pulse_end();

    // R4, R5, R11
    wr_en(8'h3F);
    go_to(0); tmr_ovf[0] = 1; tmr_ovf[2] = 1; ser_evt = 1; pulse_end();
    go_to(10);
    go_to(10);
    check("R4 global off blocks", int'(irq_valid), 0);
    go_to(0); wr_en(8'hBF);
    go_to(10);
    check("R11 t0 beats serial and t2", int'(irq_src), 1);
    go_to(0); wr_en(8'hBD);
    go_to(10);
    check("R5 t0 disabled gives serial", int'(irq_src), 4);
    go_to(0); wr_en(8'hAD);
    go_to(10);
    check("R5 serial disabled gives t2", int'(irq_src), 5);
    check("R9 serial flag kept", int'(irq_flags[4]), 1);
    sw_clr = 7'h7F; pulse_end();

    // R12: external inputs
    ext_edge = 2'b01; ext_pin = 2'b00;
    wr_en(8'h85);
    go_to(10); go_to(10);
    go_to(0); ext_pin = 2'b01;
    go_to(10);
    check("R12 edge flag set", int'(irq_flags[0]), 1);
    check("R12 edge not yet polled", int'(irq_valid), 0);
    go_to(10);
    check("R12 edge request", int'(irq_valid), 1);
    check("R11 ext0 source", int'(irq_src), 0);
    ack = 1; pulse_end();
    check("R10 edge flag cleared", int'(irq_flags[0]), 0);
    go_to(10); go_to(10);
    check("R12 held pin no retrigger", int'(irq_valid), 0);
    go_to(0); ext_pin = 2'b11;
    go_to(10);
    check("R12 level flag follows pin", int'(irq_flags[2]), 1);
    go_to(10);
    check("R12 level request", int'(irq_valid), 1);
    check("R12 level source", int'(irq_src), 2);
    ack = 1; pulse_end();
    check("R10 level flag not cleared", int'(irq_flags[2]), 1);
    go_to(10);
    check("R10 level presented again", int'(irq_valid), 1);
    go_to(0); ext_pin = 2'b00;
    go_to(10);
    check("R12 level flag drops", int'(irq_flags[2]), 0);
    go_to(10);
    check("R12 level request gone", int'(irq_valid), 0);

    // Random phase, compared every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (n % 500 == 0) ext_edge = 2'($urandom);
      en_we = ($urandom % 50) == 0;
      en_wdata = 8'($urandom) | ((($urandom % 4) != 0) ? 8'h80 : 8'h00);
      for (int b = 0; b < 3; b++) tmr_ovf[b] = ($urandom % 20) == 0;
      t2_ext_evt = ($urandom % 40) == 0;
      ser_evt = ($urandom % 30) == 0;
      for (int b = 0; b < 2; b++) if (($urandom % 16) == 0) ext_pin[b] = ~ext_pin[b];
      for (int b = 0; b < 7; b++) sw_clr[b] = ($urandom % 30) == 0;
      ack = (irq_valid && ($urandom % 3) == 0) || (($urandom % 40) == 0);
    end
    pulse_end();
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule